// File: doc/BRIEF.md
# Inline Data Upload Engine

This engine turns a stream of register writes into a run of 32-bit memory stores. Software writes a 32-bit value to a method index, either a destination base address or an origin field. It then writes the launch register, which selects linear mode and re-arms a word cursor at zero. After that, software writes each payload word, one at a time, to the payload method. Each payload write becomes exactly one store to the base address plus four bytes times the cursor, and the cursor then advances by one.

Stores leave through a single valid/ready write port. While a store waits for the memory side, the engine holds its own `cfg_ready` low. This keeps stores in the same order as the payload writes that produced them. Some writes cannot be executed: a payload write outside linear mode, a payload write with a nonzero origin, or a write to a method index outside the register window. Such a write issues no store and sets a sticky error flag. The next launch write clears that flag.

Top module: `inline_upload_eng`

## Requirements
- R1: After reset, `mem_valid` and `err_flag` are 0, `cfg_ready` is 1, and the cursor is zero. The base address, the origin fields and the linear bit are all zero.
- R2: An accepted write to method 0x6D (payload) is executed when two conditions hold: the linear bit is 1, and all three origin fields are zero. An executed payload write presents one store on the next cycle. Its data is the written value. Its address is ({method 0x62 value, method 0x63 value} + 4 × cursor), truncated to the low `ADDR_W` bits.
- R3: The cursor advances by one after each executed payload write and wraps modulo 2^`OFF_W`.
- R4: Any accepted write to method 0x6C (launch) resets the cursor to zero, loads the linear bit from value bit 0, and clears `err_flag`.
- R5: A payload write while the linear bit is 0 issues no store, leaves the cursor unchanged and sets `err_flag`.
- R6: A payload write while any origin field is nonzero issues no store, leaves the cursor unchanged and sets `err_flag`. The origin fields are method 0x69, method 0x6A and method 0x6B.
- R7: A write to a method index of 0x7F or above changes no register, issues no store and sets `err_flag`.
- R8: Once set, `err_flag` stays 1 through all later writes, including executed payload writes, until a launch write.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `cfg_ready` is 0. In that state `mem_valid`, `mem_addr` and `mem_data` hold their values on the next cycle.
- R10: Stores reach the memory port in the order of the payload writes that produced them, whatever the back-pressure pattern.
- R11: Bits of the high address word above `ADDR_W` have no effect on `mem_addr`. A carry out of the low word propagates into the high word.
- R12: Writes to the in-range methods other than 0x6D issue no store and do not change `err_flag`. This covers 0x60, 0x61 and 0x64 to 0x68, which are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Register write offered |
| cfg_ready | output | 1 | Engine can take a register write |
| cfg_method | input | 8 | Method index of the write |
| cfg_wdata | input | 32 | Value of the write |
| mem_valid | output | 1 | Store pending on the memory port |
| mem_ready | input | 1 | Memory side takes the store |
| mem_addr | output | ADDR_W | Byte address of the store |
| mem_data | output | 32 | Word to store |
| err_flag | output | 1 | Sticky unsupported-write indication |

## Verification
The bench builds the engine with `ADDR_W` = 40 and `OFF_W` = 4. With the narrow cursor, a wrap back to the base address takes only seventeen payload words, so a single sweep per base address reaches it. The 40-bit port makes both the discarded high-word bits and the carry from the low word into the high word observable on every store. The bench sweeps several base addresses, with back-pressure both off and on, and walks every origin field and every out-of-window index class.

// File: rtl/upl_pkg.sv
package upl_pkg;

  localparam int MTH_W = 8;

  localparam logic [MTH_W-1:0] M_BASE_HI = 8'h62;
  localparam logic [MTH_W-1:0] M_BASE_LO = 8'h63;
  localparam logic [MTH_W-1:0] M_ORG_Z   = 8'h69;
  localparam logic [MTH_W-1:0] M_ORG_X   = 8'h6A;
  localparam logic [MTH_W-1:0] M_ORG_Y   = 8'h6B;
  localparam logic [MTH_W-1:0] M_LAUNCH  = 8'h6C;
  localparam logic [MTH_W-1:0] M_PAYLOAD = 8'h6D;
  localparam logic [MTH_W-1:0] M_LIMIT   = 8'h7F;

  localparam int N_ORG = 3;

  // Byte address of a word: 64-bit base plus four bytes per cursor step.
  function automatic logic [63:0] word_addr(input logic [31:0] hi,
                                            input logic [31:0] lo,
                                            input logic [63:0] cur);
    return {hi, lo} + (cur << 2);
  endfunction

  // A payload write is executable only in linear mode with a zero origin.
  function automatic logic layout_ok(input logic lin,
                                     input logic [N_ORG-1:0] org_nz);
    return lin && (org_nz == '0);
  endfunction

  function automatic logic idx_legal(input logic [MTH_W-1:0] m);
    return m < M_LIMIT;
  endfunction

endpackage

// File: rtl/upl_regs.sv
module upl_regs
  import upl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MTH_W-1:0] wr_idx,
  input  logic [31:0]      wr_val,
  output logic [31:0]      base_hi,
  output logic [31:0]      base_lo,
  output logic [N_ORG-1:0] org_nz,
  output logic             lin_mode
);

  localparam logic [MTH_W-1:0] ORG_IDX [N_ORG] = '{M_ORG_Z, M_ORG_X, M_ORG_Y};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi  <= '0;
      base_lo  <= '0;
      lin_mode <= 1'b0;
    end else if (wr_en) begin
      if (wr_idx == M_BASE_HI) base_hi  <= wr_val;
      if (wr_idx == M_BASE_LO) base_lo  <= wr_val;
      if (wr_idx == M_LAUNCH)  lin_mode <= wr_val[0];
    end
  end

  // Origin fields matter only through whether they are zero.
  for (genvar g = 0; g < N_ORG; g++) begin : g_org
    always_ff @(posedge clk) begin
      if (!rst_n)
        org_nz[g] <= 1'b0;
      else if (wr_en && wr_idx == ORG_IDX[g])
        org_nz[g] <= (wr_val != '0);
    end
  end

endmodule

// File: rtl/upl_cursor.sv
module upl_cursor #(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             step,
  output logic [OFF_W-1:0] cur
);

  always_ff @(posedge clk) begin
    if (!rst_n)     cur <= '0;
    else if (rearm) cur <= '0;
    else if (step)  cur <= cur + OFF_W'(1);
  end

endmodule

// File: rtl/upl_store.sv
module upl_store #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [31:0]       load_data,
  output logic              can_take,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data
);

  assign can_take = !mem_valid || mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= load_addr;
      mem_data  <= load_data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/inline_upload_eng.sv
module inline_upload_eng
  import upl_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [7:0]        cfg_method,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              err_flag
);

  logic             acc, legal, bad_idx, exec_hit, data_hit, store_go, bad_data;
  logic [31:0]      base_hi, base_lo;
  logic [N_ORG-1:0] org_nz;
  logic             lin_mode;
  logic [OFF_W-1:0] cur_off;

  assign acc      = cfg_valid && cfg_ready;
  assign legal    = idx_legal(cfg_method);
  assign bad_idx  = acc && !legal;
  assign exec_hit = acc && cfg_method == M_LAUNCH;
  assign data_hit = acc && cfg_method == M_PAYLOAD;
  assign store_go = data_hit && layout_ok(lin_mode, org_nz);
  assign bad_data = data_hit && !layout_ok(lin_mode, org_nz);

  upl_regs regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc && legal),
    .wr_idx  (cfg_method),
    .wr_val  (cfg_wdata),
    .base_hi (base_hi),
    .base_lo (base_lo),
    .org_nz  (org_nz),
    .lin_mode(lin_mode)
  );

  upl_cursor #(.OFF_W(OFF_W)) cursor_i (
    .clk  (clk),
    .rst_n(rst_n),
    .rearm(exec_hit),
    .step (store_go),
    .cur  (cur_off)
  );

  upl_store #(.ADDR_W(ADDR_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (store_go),
    .load_addr(ADDR_W'(word_addr(base_hi, base_lo, 64'(cur_off)))),
    .load_data(cfg_wdata),
    .can_take (cfg_ready),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_data (mem_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_flag <= 1'b0;
    else if (exec_hit)             err_flag <= 1'b0;
    else if (bad_idx || bad_data)  err_flag <= 1'b1;
  end

endmodule

// File: rtl/upl_chk.sv
module upl_chk #(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic              err_flag,
  input logic              exec_hit,
  input logic              bad_idx,
  input logic              bad_data,
  input logic              store_go,
  input logic [OFF_W-1:0]  cur_off
);

  // R2
  store_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> mem_valid);

  // R3
  cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_go && !exec_hit |=> cur_off == $past(cur_off) + OFF_W'(1));

  // R4
  launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_hit |=> cur_off == '0 && !err_flag);

  // R5
  bad_data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_data |=> err_flag && $stable(cur_off));

  // R7
  bad_idx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx |=> err_flag);

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !exec_hit |=> err_flag);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !cfg_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

endmodule

bind inline_upload_eng upl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_ready(cfg_ready),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_data (mem_data),
  .err_flag (err_flag),
  .exec_hit (exec_hit),
  .bad_idx  (bad_idx),
  .bad_data (bad_data),
  .store_go (store_go),
  .cur_off  (cur_off)
);

// File: tb/inline_upload_eng_tb_top.sv
`timescale 1ns/1ps
module inline_upload_eng_tb_top;

  localparam int AW = 40;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [7:0]    cfg_method = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          mem_valid;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data;
  logic          err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stall_on = 0;
  int cyc = 0;

  // bench model
  logic [31:0] m_hi = 0, m_lo = 0;
  logic [31:0] m_x = 0, m_y = 0, m_z = 0;
  bit m_lin = 0, m_err = 0;
  int m_off = 0;
  logic [AW-1:0] exp_a[$];
  logic [31:0]   exp_d[$];

  always #2 clk = ~clk;

  inline_upload_eng #(.ADDR_W(AW), .OFF_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_method(cfg_method), .cfg_wdata(cfg_wdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // back-pressure pattern, driven just after the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    mem_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
  end

  // store monitor at the falling edge
  bit hold_pend = 0;
  logic [AW-1:0] hold_a;
  logic [31:0]   hold_d;
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (hold_pend) begin
        chk("R9 addr hold", 64'(mem_addr), 64'(hold_a));
        chk("R9 data hold", 64'(mem_data), 64'(hold_d));
      end
      if (mem_ready) begin
        hold_pend = 0;
        if (exp_a.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected store actual=%0h expected=none", mem_addr);
        end else begin
          chk("R2 R10 R11 addr", 64'(mem_addr), 64'(exp_a.pop_front()));
          chk("R2 R10 data", 64'(mem_data), 64'(exp_d.pop_front()));
        end
      end else begin
        chk("R9 cfg_ready low", 64'(cfg_ready), 64'd0);
        hold_pend = 1; hold_a = mem_addr; hold_d = mem_data;
      end
    end else begin
      hold_pend = 0;
    end
  end

  task automatic put(input logic [7:0] m, input logic [31:0] v, input string req);
    logic [63:0] full;
    @(negedge clk);
    cfg_method = m; cfg_wdata = v; cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    // accepted at the coming edge: update the model first
    if (m >= 8'h7F) m_err = 1;
    else case (m)
      8'h62: m_hi = v;
      8'h63: m_lo = v;
      8'h69: m_z = v;
      8'h6A: m_x = v;
      8'h6B: m_y = v;
      8'h6C: begin m_lin = v[0]; m_off = 0; m_err = 0; end
      8'h6D: begin
        if (m_lin && m_x == 0 && m_y == 0 && m_z == 0) begin
          full = {m_hi, m_lo} + 64'(m_off) * 64'd4;
          exp_a.push_back(full[AW-1:0]);
          exp_d.push_back(v);
          m_off = (m_off + 1) % (1 << OW);
        end else m_err = 1;
      end
      default: ;
    endcase
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(req, 64'(err_flag), 64'(m_err));
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
    chk("R10 queue empty", 64'(exp_a.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] his [4];
    logic [31:0] los [4];
    his = '{32'h0, 32'hFFFF_FF12, 32'h0000_0034, 32'hABCD_0000};
    los = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h8000_0004, 32'h0};
    repeat (3) @(negedge clk);
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 err_flag", 64'(err_flag), 64'd0);
    chk("R1 cfg_ready", 64'(cfg_ready), 64'd1);
    rst_n = 1'b1;
    // R1: reset left linear bit 0, so payload errors
    put(8'h6D, 32'h1111, "R1 R5 payload before launch");
    // R1: base and cursor zero after reset
    put(8'h6C, 32'h1, "R4 launch clears err");
    put(8'h6D, 32'h2222, "R1 zero base store");
    drain();

    // R2 R3 R11: sweep bases, back-pressure off then on
    for (int s = 0; s < 2; s++) begin
      stall_on = (s == 1);
      for (int b = 0; b < 4; b++) begin
        put(8'h62, his[b], "R12 base hi");
        put(8'h63, los[b], "R12 base lo");
        put(8'h6C, 32'h3, "R4 launch");
        for (int k = 0; k < 20; k++)
          put(8'h6D, 32'hC000_0000 + 32'(b * 100 + k), "R3 sweep");
        drain();
      end
    end
    stall_on = 1;

    // R5: linear bit clear
    put(8'h6C, 32'h0, "R4 launch nonlinear");
    put(8'h6D, 32'hDEAD, "R5 payload nonlinear");
    put(8'h6D, 32'hBEEF, "R8 stays set");
    put(8'h6C, 32'h1, "R4 clears error");
    drain();

    // R6: each origin field in turn; cursor must not move
    for (int f = 0; f < 3; f++) begin
      put(8'h6C, 32'h1, "R4 launch");
      put(8'h6D, 32'h5000 + 32'(f), "R6 good word");
      put(8'h69 + 8'(f), 32'h1 << f, "R12 origin");
      put(8'h6D, 32'h6000, "R6 origin nonzero");
      put(8'h69 + 8'(f), 32'h0, "R8 sticky");
      put(8'h6D, 32'h7000 + 32'(f), "R8 sticky after good store");
      drain();
    end

    // R7: out-of-window indices
    put(8'h6C, 32'h1, "R4 launch");
    put(8'h7F, 32'h1, "R7 index 7F");
    put(8'h6C, 32'h1, "R4 launch");
    put(8'hED, 32'h9999, "R7 index ED no store");
    put(8'hE3, 32'h0000_4444, "R7 lo not changed");
    put(8'hFF, 32'h0, "R7 index FF");
    put(8'h6C, 32'h1, "R4 launch");
    put(8'h6D, 32'hAAAA, "R7 base intact");
    drain();

    // R12: other in-range methods
    put(8'h60, 32'h10, "R12 line length");
    put(8'h61, 32'h2, "R12 line count");
    for (int i = 0; i < 5; i++) put(8'h64 + 8'(i), 32'hFFFF_FFFF, "R12 geometry");
    put(8'h00, 32'h7, "R12 low index");
    put(8'h6D, 32'hBBBB, "R12 cursor continues");
    drain();
    chk("R9 idle mem_valid", 64'(mem_valid), 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule